// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Checker

This block sits between decode and register-file read in a two-pipe in-order core. Each cycle it sees two decoded instructions. The older one is in slot U and the younger one is in slot V. It decides whether both may go down the two parallel pipes together, or whether only the older one proceeds. When V cannot go, the block asserts a hold so the front end keeps the younger instruction, and that instruction moves into slot U in the next cycle.

V pairs with U only when all of these are true:
- The two instructions are data-independent. V reads no register that U writes, and V does not write the register U writes.
- The second pipe can execute the V instruction.
- Neither instruction needs both pipes.

Register 0 never creates a dependency. The decision is computed combinationally and registered, so the outputs follow the inputs by one clock.

Top module: `pair_issue_gate`

## Requirements
- R1: While `rst` is high at a rising edge, `issue_u`, `issue_v` and `hold_v` are all 0 after that edge.
- R2: The outputs change one clock after the inputs that cause them. With `stall` low and `u_valid` high, `issue_u` is 1.
- R3: If U has `u_wen`=1 and a nonzero `u_dst` that equals `v_src0` or `v_src1`, then `issue_v` is 0. When `u_wen`=0, this read match has no effect.
- R4: If both instructions write (`u_wen`=`v_wen`=1) to the same nonzero destination, then `issue_v` is 0.
- R5: Register 0 never creates a dependency. A match on register number 0 has no effect on pairing.
- R6: V may pair only when `v_vpipe_ok`=1 and bit `v_cls` of parameter `V_CLASS_MASK` is 1. The default mask is 4'b0011, so classes 0 and 1 are allowed.
- R7: If `u_both` or `v_both` is 1, then `issue_v` is 0.
- R8: If V is invalid, then `issue_v`=0 and `hold_v`=0. If U is invalid and V is valid, then V is not issued and `hold_v`=1.
- R9: If V is valid and pairing is refused while `stall` is low, then `issue_u`=`u_valid`, `issue_v`=0 and `hold_v`=1.
- R10: While `stall`=1, `issue_u`=0 and `issue_v`=0, and `hold_v` equals `v_valid`.
- R11: A valid, independent and capable pair with `stall` low gives `issue_u`=1, `issue_v`=1 and `hold_v`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze both slots this cycle |
| u_valid | input | 1 | Older slot holds an instruction |
| u_dst | input | REG_W | Older destination register |
| u_src0 | input | REG_W | Older first source register |
| u_src1 | input | REG_W | Older second source register |
| u_wen | input | 1 | Older writes its destination |
| u_cls | input | CLS_W | Older opcode class |
| u_both | input | 1 | Older needs both pipes |
| u_vpipe_ok | input | 1 | Older is executable by the second pipe |
| v_valid | input | 1 | Younger slot holds an instruction |
| v_dst | input | REG_W | Younger destination register |
| v_src0 | input | REG_W | Younger first source register |
| v_src1 | input | REG_W | Younger second source register |
| v_wen | input | 1 | Younger writes its destination |
| v_cls | input | CLS_W | Younger opcode class |
| v_both | input | 1 | Younger needs both pipes |
| v_vpipe_ok | input | 1 | Younger is executable by the second pipe |
| issue_u | output | 1 | Older instruction goes to the first pipe |
| issue_v | output | 1 | Younger instruction goes to the second pipe |
| hold_v | output | 1 | Keep the younger instruction for the next cycle |

## Verification
The assertions assume that the source and destination fields are meaningful only when the matching valid bit is set. They also assume that `stall` and all slot fields are stable around the clock edge, because the bench drives them on the falling edge.

The properties look back one cycle. Each one requires that reset was low in that earlier cycle, so a pair presented during reset is never judged.

The stimulus holds every field constant for a full cycle. It mixes directed corner cases with random patterns over only four register numbers, so that read and write collisions, including register 0, occur often.

// File: rtl/pair_pkg.sv
package pair_pkg;
  typedef struct packed {
    logic raw;
    logic waw;
  } hazard_t;

  typedef struct packed {
    logic iu;
    logic iv;
    logic hv;
  } verdict_t;
endpackage

// File: rtl/pair_dep_check.sv
module pair_dep_check #(
  parameter int REG_W = 5
) (
  input  logic             u_wen,
  input  logic [REG_W-1:0] u_dst,
  input  logic             v_wen,
  input  logic [REG_W-1:0] v_dst,
  input  logic [REG_W-1:0] v_src0,
  input  logic [REG_W-1:0] v_src1,
  output pair_pkg::hazard_t haz
);
  localparam int NSRC = 2;
  logic [REG_W-1:0] srcs [NSRC];
  logic [NSRC-1:0]  hit;
  logic             u_writes;

  assign srcs[0]  = v_src0;
  assign srcs[1]  = v_src1;
  assign u_writes = u_wen && (u_dst != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = u_writes && (srcs[g] == u_dst);
  end

  always_comb begin
    haz.raw = |hit;
    haz.waw = u_writes && v_wen && (v_dst == u_dst);
  end
endmodule

// File: rtl/pair_cap_check.sv
module pair_cap_check #(
  parameter int CLS_W = 2,
  parameter logic [(1<<CLS_W)-1:0] V_CLASS_MASK = 4'b0011
) (
  input  logic             u_both,
  input  logic             v_both,
  input  logic             v_vpipe_ok,
  input  logic [CLS_W-1:0] v_cls,
  output logic             cap_ok
);
  localparam int NCLS = 1 << CLS_W;
  logic [NCLS-1:0] cls_hot;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    assign cls_hot[c] = (v_cls == c[CLS_W-1:0]) && V_CLASS_MASK[c];
  end

  assign cap_ok = v_vpipe_ok && (|cls_hot) && !u_both && !v_both;
endmodule

// File: rtl/pair_issue_gate.sv
module pair_issue_gate #(
  parameter int REG_W = 5,
  parameter int CLS_W = 2,
  parameter logic [(1<<CLS_W)-1:0] V_CLASS_MASK = 4'b0011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic             u_valid,
  input  logic [REG_W-1:0] u_dst,
  input  logic [REG_W-1:0] u_src0,
  input  logic [REG_W-1:0] u_src1,
  input  logic             u_wen,
  input  logic [CLS_W-1:0] u_cls,
  input  logic             u_both,
  input  logic             u_vpipe_ok,
  input  logic             v_valid,
  input  logic [REG_W-1:0] v_dst,
  input  logic [REG_W-1:0] v_src0,
  input  logic [REG_W-1:0] v_src1,
  input  logic             v_wen,
  input  logic [CLS_W-1:0] v_cls,
  input  logic             v_both,
  input  logic             v_vpipe_ok,
  output logic             issue_u,
  output logic             issue_v,
  output logic             hold_v
);
  import pair_pkg::*;

  hazard_t  haz;
  logic     cap_ok;
  logic     pair_ok;
  verdict_t nxt;
  verdict_t cur;
  logic     unused_ok;

  assign unused_ok = ^{u_src0, u_src1, u_cls, u_vpipe_ok};

  pair_dep_check #(.REG_W(REG_W)) i_dep (
    .u_wen (u_wen),
    .u_dst (u_dst),
    .v_wen (v_wen),
    .v_dst (v_dst),
    .v_src0(v_src0),
    .v_src1(v_src1),
    .haz   (haz)
  );

  pair_cap_check #(.CLS_W(CLS_W), .V_CLASS_MASK(V_CLASS_MASK)) i_cap (
    .u_both    (u_both),
    .v_both    (v_both),
    .v_vpipe_ok(v_vpipe_ok),
    .v_cls     (v_cls),
    .cap_ok    (cap_ok)
  );

  assign pair_ok = u_valid && v_valid && cap_ok && !haz.raw && !haz.waw;

  always_comb begin
    if (stall) begin
      nxt.iu = 1'b0;
      nxt.iv = 1'b0;
      nxt.hv = v_valid;
    end else begin
      nxt.iu = u_valid;
      nxt.iv = pair_ok;
      nxt.hv = v_valid && !pair_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= '0;
    else     cur <= nxt;
  end

  assign issue_u = cur.iu;
  assign issue_v = cur.iv;
  assign hold_v  = cur.hv;
endmodule

// File: rtl/pair_issue_chk.sv
module pair_issue_chk #(
  parameter int REG_W = 5,
  parameter int CLS_W = 2,
  parameter logic [(1<<CLS_W)-1:0] V_CLASS_MASK = 4'b0011
) (
  input logic             clk,
  input logic             rst,
  input logic             stall,
  input logic             u_valid,
  input logic [REG_W-1:0] u_dst,
  input logic             u_wen,
  input logic             u_both,
  input logic             v_valid,
  input logic [REG_W-1:0] v_dst,
  input logic [REG_W-1:0] v_src0,
  input logic [REG_W-1:0] v_src1,
  input logic             v_wen,
  input logic [CLS_W-1:0] v_cls,
  input logic             v_both,
  input logic             v_vpipe_ok,
  input logic             issue_u,
  input logic             issue_v,
  input logic             hold_v
);
  logic raw_seen;
  logic waw_seen;
  logic cap_bad;

  assign raw_seen = u_wen && (u_dst != '0) && ((v_src0 == u_dst) || (v_src1 == u_dst));
  assign waw_seen = u_wen && v_wen && (u_dst != '0) && (v_dst == u_dst);
  assign cap_bad  = !v_vpipe_ok || !V_CLASS_MASK[v_cls];

  assert_rst_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> !issue_u && !issue_v && !hold_v);

  assert_u_issue_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(u_valid) && !$past(stall)) |-> issue_u);

  assert_raw_block_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(raw_seen)) |-> !issue_v);

  assert_waw_block_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(waw_seen)) |-> !issue_v);

  assert_cap_block_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cap_bad)) |-> !issue_v);

  assert_both_block_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(u_both || v_both)) |-> !issue_v);

  assert_v_invalid_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(v_valid)) |-> !issue_v && !hold_v);

  assert_v_needs_u_R9: assert property (@(posedge clk) disable iff (rst)
    issue_v |-> issue_u && !hold_v);

  assert_stall_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stall)) |-> !issue_u && !issue_v && (hold_v == $past(v_valid)));
endmodule

bind pair_issue_gate pair_issue_chk #(
  .REG_W(REG_W), .CLS_W(CLS_W), .V_CLASS_MASK(V_CLASS_MASK)
) i_chk (
  .clk(clk), .rst(rst), .stall(stall),
  .u_valid(u_valid), .u_dst(u_dst), .u_wen(u_wen), .u_both(u_both),
  .v_valid(v_valid), .v_dst(v_dst), .v_src0(v_src0), .v_src1(v_src1),
  .v_wen(v_wen), .v_cls(v_cls), .v_both(v_both), .v_vpipe_ok(v_vpipe_ok),
  .issue_u(issue_u), .issue_v(issue_v), .hold_v(hold_v)
);

// File: tb/test_pair_issue_gate.sv
module test_pair_issue_gate;
  localparam int REG_W = 5;
  localparam int CLS_W = 2;
  localparam logic [3:0] MASK = 4'b0011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stall = 1'b0;
  logic u_valid = 0, u_wen = 0, u_both = 0, u_vpipe_ok = 0;
  logic v_valid = 0, v_wen = 0, v_both = 0, v_vpipe_ok = 0;
  logic [REG_W-1:0] u_dst = 0, u_src0 = 0, u_src1 = 0;
  logic [REG_W-1:0] v_dst = 0, v_src0 = 0, v_src1 = 0;
  logic [CLS_W-1:0] u_cls = 0, v_cls = 0;
  logic issue_u, issue_v, hold_v;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    logic  iu;
    logic  iv;
    logic  hv;
    string tag;
  } exp_t;
  exp_t sb [$];

  always #2.5 clk = ~clk;

  pair_issue_gate #(.REG_W(REG_W), .CLS_W(CLS_W), .V_CLASS_MASK(MASK)) i_pair_issue_gate (
    .clk(clk), .rst(rst), .stall(stall),
    .u_valid(u_valid), .u_dst(u_dst), .u_src0(u_src0), .u_src1(u_src1),
    .u_wen(u_wen), .u_cls(u_cls), .u_both(u_both), .u_vpipe_ok(u_vpipe_ok),
    .v_valid(v_valid), .v_dst(v_dst), .v_src0(v_src0), .v_src1(v_src1),
    .v_wen(v_wen), .v_cls(v_cls), .v_both(v_both), .v_vpipe_ok(v_vpipe_ok),
    .issue_u(issue_u), .issue_v(issue_v), .hold_v(hold_v)
  );

  task automatic check3(string tag, logic ai, logic av, logic ah, logic ei, logic ev, logic eh);
    checks++;
    if ({ai, av, ah} !== {ei, ev, eh}) begin
      fails++;
      $display("FAIL %s: got u=%b v=%b hold=%b expected u=%b v=%b hold=%b",
               tag, ai, av, ah, ei, ev, eh);
    end
  endtask

  task automatic drive(string tag, bit st,
                       bit uv, int ud, int us0, int us1, bit uw, int uc, bit ub,
                       bit vv, int vd, int vs0, int vs1, bit vw, int vc, bit vb, bit vk);
    exp_t e;
    bit dep, cap, pr;
    @(negedge clk);
    stall = st;
    u_valid = uv; u_dst = ud[REG_W-1:0]; u_src0 = us0[REG_W-1:0]; u_src1 = us1[REG_W-1:0];
    u_wen = uw; u_cls = uc[CLS_W-1:0]; u_both = ub; u_vpipe_ok = 1'b0;
    v_valid = vv; v_dst = vd[REG_W-1:0]; v_src0 = vs0[REG_W-1:0]; v_src1 = vs1[REG_W-1:0];
    v_wen = vw; v_cls = vc[CLS_W-1:0]; v_both = vb; v_vpipe_ok = vk;
    dep = uw && (ud != 0) && ((vs0 == ud) || (vs1 == ud) || (vw && vd == ud));
    cap = vk && MASK[vc] && !ub && !vb;
    pr  = uv && vv && !st && !dep && cap;
    e.iu = uv && !st;
    e.iv = pr;
    e.hv = vv && (st || !pr);
    e.tag = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check3(e.tag, issue_u, issue_v, hold_v, e.iu, e.iv, e.hv);
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs low even with a pairable pair presented
    u_valid = 1; v_valid = 1; v_vpipe_ok = 1;
    v_dst = 4; u_dst = 3; u_wen = 1;
    repeat (3) @(posedge clk);
    #1;
    check3("R1 reset", issue_u, issue_v, hold_v, 0, 0, 0);
    @(negedge clk);
    rst = 0;

    drive("R11 independent pair", 0, 1,3,1,2,1,0,0, 1,4,5,6,1,1,0,1);
    drive("R3 raw on src0", 0, 1,3,1,2,1,0,0, 1,4,3,6,1,1,0,1);
    drive("R3 raw on src1", 0, 1,3,1,2,1,0,0, 1,4,5,3,1,1,0,1);
    drive("R3 no write no raw", 0, 1,3,1,2,0,0,0, 1,4,3,3,1,0,0,1);
    drive("R4 waw", 0, 1,7,1,2,1,0,0, 1,7,5,6,1,0,0,1);
    drive("R4 waw only v writes ok", 0, 1,7,1,2,0,0,0, 1,7,5,6,1,0,0,1);
    drive("R5 r0 no dependency", 0, 1,0,1,2,1,0,0, 1,0,0,0,1,0,0,1);
    drive("R6 v pipe flag low", 0, 1,3,1,2,1,0,0, 1,4,5,6,1,0,0,0);
    drive("R6 class 2 refused", 0, 1,3,1,2,1,0,0, 1,4,5,6,1,2,0,1);
    drive("R6 class 3 refused", 0, 1,3,1,2,1,0,0, 1,4,5,6,1,3,0,1);
    drive("R7 u both pipes", 0, 1,3,1,2,1,0,1, 1,4,5,6,1,0,0,1);
    drive("R7 v both pipes", 0, 1,3,1,2,1,0,0, 1,4,5,6,1,0,1,1);
    drive("R8 v invalid", 0, 1,3,1,2,1,0,0, 0,4,5,6,1,0,0,1);
    drive("R8 u invalid v held", 0, 0,3,1,2,1,0,0, 1,4,5,6,1,0,0,1);
    drive("R2 u only", 0, 1,9,1,2,1,0,0, 0,0,0,0,0,0,0,0);
    drive("R9 refused holds v", 0, 1,3,1,2,1,0,0, 1,3,3,6,1,0,0,1);
    drive("R10 stall pair", 1, 1,3,1,2,1,0,0, 1,4,5,6,1,0,0,1);
    drive("R10 stall v invalid", 1, 1,3,1,2,1,0,0, 0,4,5,6,1,0,0,1);
    drive("R11 after stall", 0, 1,3,1,2,1,0,0, 1,4,5,6,1,1,0,1);
    drive("R8 both invalid", 0, 0,3,1,2,1,0,0, 0,4,5,6,1,0,0,1);

    for (int i = 0; i < 400; i++) begin
      drive("R9 random mix", ($urandom % 8) == 0,
            ($urandom % 8) != 0, $urandom % 4, $urandom % 4, $urandom % 4,
            $urandom % 2, $urandom % 4, ($urandom % 8) == 0,
            ($urandom % 8) != 0, $urandom % 4, $urandom % 4, $urandom % 4,
            $urandom % 2, $urandom % 4, ($urandom % 8) == 0, ($urandom % 4) != 0);
    end

    @(negedge clk);
    u_valid = 0; v_valid = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule